// File: doc/BRIEF.md
# Translation Mapping Replay Walker

The block rebuilds the set of live mappings of one translation window so that a downstream listener can resynchronise, for example a device-side translation cache that has lost its contents. When it is started, it latches the page shift and the entry count. It then looks up each page of the window in turn, starting at address 0 and stepping by the page size (2 to the power of the page shift). Every entry that grants some access produces one mapping record on a valid/ready stream.

A lookup is a one-cycle request pulse carrying a byte address. The translation table answers with a response-valid strobe and the 64-bit entry, whose two low bits hold the access rights. The walk stops when the address reaches the end of the window. It also stops if the next step would carry out of the address counter, so it always ends. A skip input makes a start request finish at once without any lookup. A busy level and a one-cycle done pulse frame each operation.

Top module: `replay_walker`

## Requirements
- R1: After reset, busy, done, lk_req and rec_valid are all low.
- R2: Lookups start at address 0. Each following lookup address is the previous one plus 2^page_shift. lk_req is a one-cycle pulse.
- R3: The access field is bits [1:0] of the entry: 0 no access, 1 read only, 2 write only, 3 read and write. An entry with field 0 produces no record. Any other value produces exactly one record.
- R4: A record carries rec_iova = the lookup address, rec_xlat = entry with its low page_shift bits cleared, rec_mask = 2^page_shift - 1, and rec_perm = entry[1:0].
- R5: The walk makes exactly one lookup for each address below entry_count << page_shift. An entry count of zero finishes with no lookup.
- R6: If adding the step to the current address would carry out of the 64-bit counter, the walk ends after that lookup, even when the window limit has not been reached.
- R7: A start with skip high makes no lookup and no record. Busy stays low and done pulses in the following cycle.
- R8: While rec_valid is high and rec_ready is low, the record stays valid and unchanged. No record is lost or repeated.
- R9: Busy is high from the cycle after an accepted start until completion. Done is high for exactly one cycle per walk, and busy is low while done is high.
- R10: A start request while busy is ignored. The running walk keeps its latched configuration and gives exactly one done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken while idle |
| skip | input | 1 | Suppress the walk for this start |
| page_shift | input | SHW | Log2 of page size, latched at start |
| entry_count | input | CNTW | Number of table entries, latched at start |
| lk_req | output | 1 | Lookup request pulse |
| lk_addr | output | AW | Lookup byte address |
| lk_rsp_valid | input | 1 | Lookup response strobe |
| lk_rsp_entry | input | AW | Looked-up entry; bits [1:0] are access rights |
| rec_valid | output | 1 | Mapping record valid |
| rec_ready | input | 1 | Listener accepts record |
| rec_iova | output | AW | IO virtual address of the page |
| rec_xlat | output | AW | Translated page address |
| rec_mask | output | AW | Offset mask within the page |
| rec_perm | output | 2 | Access rights of the record |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong address register shows up on lk_addr at the very next lookup pulse, as a missed or repeated page or a misaligned address. A wrong limit or carry test shows up as one lookup too many or too few before done, or as a walk that never ends. If the latched entry is corrupted, or the emit state ends too early, the record fields change or disappear while the listener stalls. These faults become visible in the cycle the handshake was due. A stray state after skip or completion shows as busy or done at the wrong cycle, one cycle after the start edge.

// File: rtl/replay_walker.sv
module replay_walker #(
  parameter int AW   = 64,
  parameter int CNTW = 32,
  parameter int SHW  = $clog2(AW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            skip,
  input  logic [SHW-1:0]  page_shift,
  input  logic [CNTW-1:0] entry_count,
  output logic            lk_req,
  output logic [AW-1:0]   lk_addr,
  input  logic            lk_rsp_valid,
  input  logic [AW-1:0]   lk_rsp_entry,
  output logic            rec_valid,
  input  logic            rec_ready,
  output logic [AW-1:0]   rec_iova,
  output logic [AW-1:0]   rec_xlat,
  output logic [AW-1:0]   rec_mask,
  output logic [1:0]      rec_perm,
  output logic            busy,
  output logic            done
);

  localparam int WW = AW + CNTW;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_EMIT, S_ADV} state_t;

  state_t          st;
  logic [AW-1:0]   addr;
  logic [AW-1:0]   ent_q;
  logic [SHW-1:0]  shift_q;
  logic [CNTW-1:0] cnt_q;
  logic            done_q;

  logic [AW-1:0] step;
  logic [AW-1:0] mask;
  logic [WW-1:0] window;
  logic [AW:0]   nxt;
  logic          wrap;
  logic          at_limit;

  assign step     = {{(AW-1){1'b0}}, 1'b1} << shift_q;
  assign mask     = step - 1'b1;
  assign window   = WW'(cnt_q) << shift_q;
  assign nxt      = {1'b0, addr} + {1'b0, step};
  assign wrap     = nxt[AW];
  assign at_limit = WW'(nxt[AW-1:0]) >= window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr    <= '0;
      ent_q   <= '0;
      shift_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (skip || entry_count == '0) begin
            done_q <= 1'b1;
          end else begin
            shift_q <= page_shift;
            cnt_q   <= entry_count;
            addr    <= '0;
            st      <= S_REQ;
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (lk_rsp_valid) begin
          ent_q <= lk_rsp_entry;
          st    <= (lk_rsp_entry[1:0] != 2'd0) ? S_EMIT : S_ADV;
        end
        S_EMIT: if (rec_ready) st <= S_ADV;
        S_ADV: begin
          if (wrap || at_limit) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            addr <= nxt[AW-1:0];
            st   <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lk_req    = (st == S_REQ);
  assign lk_addr   = addr;
  assign rec_valid = (st == S_EMIT);
  assign rec_iova  = addr;
  assign rec_xlat  = ent_q & ~mask;
  assign rec_mask  = mask;
  assign rec_perm  = ent_q[1:0];
  assign busy      = (st != S_IDLE);
  assign done      = done_q;

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> !lk_req);

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> ((lk_addr & rec_mask) == '0));

  p_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> (WW'(lk_addr) < window));

  p_no_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_perm != 2'd0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_iova) &&
                                   $stable(rec_xlat) && $stable(rec_perm)));

  p_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && skip && !busy) |=> (done && !busy));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(shift_q) && $stable(cnt_q)));

endmodule

// File: tb/replay_walker_tb.sv
`timescale 1ns/1ps
module replay_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        skip = 1'b0;
  logic [5:0]  page_shift = 6'd0;
  logic [31:0] entry_count = 32'd0;
  logic        lk_req;
  logic [63:0] lk_addr;
  logic        lk_rsp_valid = 1'b0;
  logic [63:0] lk_rsp_entry = 64'd0;
  logic        rec_valid;
  logic        rec_ready = 1'b0;
  logic [63:0] rec_iova, rec_xlat, rec_mask;
  logic [1:0]  rec_perm;
  logic        busy, done;

  replay_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .skip(skip),
    .page_shift(page_shift), .entry_count(entry_count),
    .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_entry(lk_rsp_entry),
    .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_iova(rec_iova), .rec_xlat(rec_xlat), .rec_mask(rec_mask),
    .rec_perm(rec_perm), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;

  logic [63:0] tbl [8];
  logic [5:0]  tshift = 6'd0;
  bit          stall_mode = 1'b0;
  logic [7:0]  cyc = 8'd0;

  int          n_lk = 0, n_rec = 0, n_done = 0, hold_err = 0;
  logic [63:0] lk_log [64];
  logic [63:0] ri_log [64];
  logic [63:0] rx_log [64];
  logic [63:0] rm_log [64];
  logic [1:0]  rp_log [64];

  logic        pv = 1'b0;
  logic [63:0] p_iova = '0, p_xlat = '0;
  logic [1:0]  p_perm = '0;

  always @(posedge clk) begin
    cyc          <= cyc + 8'd1;
    rec_ready    <= stall_mode ? (cyc[1:0] == 2'd3) : 1'b1;
    lk_rsp_valid <= lk_req;
    lk_rsp_entry <= tbl[3'((lk_addr >> tshift) & 64'd7)];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !(rec_valid && rec_iova == p_iova && rec_xlat == p_xlat && rec_perm == p_perm))
        hold_err++;
      pv     = rec_valid && !rec_ready;
      p_iova = rec_iova;
      p_xlat = rec_xlat;
      p_perm = rec_perm;
      if (lk_req) begin lk_log[n_lk & 63] = lk_addr; n_lk++; end
      if (rec_valid && rec_ready) begin
        ri_log[n_rec & 63] = rec_iova;
        rx_log[n_rec & 63] = rec_xlat;
        rm_log[n_rec & 63] = rec_mask;
        rp_log[n_rec & 63] = rec_perm;
        n_rec++;
      end
      if (done) n_done++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !lk_req && !rec_valid, "R1 outputs low in reset",
        {60'd0, busy, done, lk_req, rec_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !lk_req && !rec_valid, "R1 outputs low after reset",
        {60'd0, busy, done, lk_req, rec_valid}, 64'd0);
  endtask

  task automatic t_quick(input bit sk, input logic [31:0] cnt, input string tag);
    int b_lk = n_lk, b_rec = n_rec, b_done = n_done;
    page_shift = 6'd12; entry_count = cnt; tshift = 6'd12;
    start = 1'b1; skip = sk;
    @(negedge clk);
    start = 1'b0; skip = 1'b0;
    chk(done && !busy, {tag, " done next cycle, busy low"}, {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    chk(!done, {tag, " R9 done single cycle"}, {63'd0, done}, 64'd0);
    repeat (6) @(negedge clk);
    chk(!busy, {tag, " busy stays low"}, {63'd0, busy}, 64'd0);
    chk(n_lk == b_lk, {tag, " no lookup"}, 64'(n_lk - b_lk), 64'd0);
    chk(n_rec == b_rec, {tag, " no record"}, 64'(n_rec - b_rec), 64'd0);
    chk(n_done == b_done + 1, {tag, " one done"}, 64'(n_done - b_done), 64'd1);
  endtask

  task automatic run_walk(input logic [5:0] sh, input logic [31:0] cnt,
                          input bit stall, input bit poke, input string tag);
    int b_lk, b_rec, b_done, b_hold, ne, nr;
    bit got;
    logic [127:0] a, win, stp;
    logic [63:0] e_addr [64];
    logic [63:0] ent, msk;
    b_lk = n_lk; b_rec = n_rec; b_done = n_done; b_hold = hold_err;
    tshift = sh; page_shift = sh; entry_count = cnt; stall_mode = stall;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, {tag, " R9 busy after start"}, {63'd0, busy}, 64'd1);
    if (poke) begin
      repeat (2) @(negedge clk);
      chk(busy, {tag, " R10 busy at second start"}, {63'd0, busy}, 64'd1);
      start = 1'b1; page_shift = 6'd1; entry_count = 32'd1;
      @(negedge clk);
      start = 1'b0; page_shift = sh; entry_count = cnt;
    end
    got = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, {tag, " R9 walk completes"}, {63'd0, got}, 64'd1);
    chk(!busy, {tag, " R9 busy low at done"}, {63'd0, busy}, 64'd0);
    @(negedge clk);
    chk(!done, {tag, " R9 done single cycle"}, {63'd0, done}, 64'd0);
    stall_mode = 1'b0;

    win = 128'(cnt) << sh;
    stp = 128'd1 << sh;
    msk = 64'(stp - 128'd1);
    a = '0; ne = 0;
    while (a < win && ne < 64) begin
      e_addr[ne] = a[63:0];
      ne++;
      if ((a + stp) >> 64 != 128'd0) break;
      a = a + stp;
    end
    chk(n_lk - b_lk == ne, {tag, " R5 R6 lookup count"}, 64'(n_lk - b_lk), 64'(ne));
    for (int i = 0; i < ne; i++)
      if (i < n_lk - b_lk)
        chk(lk_log[(b_lk + i) & 63] == e_addr[i], {tag, " R2 lookup address"},
            lk_log[(b_lk + i) & 63], e_addr[i]);
    nr = 0;
    for (int i = 0; i < ne; i++) begin
      ent = tbl[3'((e_addr[i] >> sh) & 64'd7)];
      if (ent[1:0] != 2'd0) begin
        if (nr < n_rec - b_rec) begin
          chk(ri_log[(b_rec + nr) & 63] == e_addr[i], {tag, " R4 record iova"},
              ri_log[(b_rec + nr) & 63], e_addr[i]);
          chk(rx_log[(b_rec + nr) & 63] == (ent & ~msk), {tag, " R4 record xlat"},
              rx_log[(b_rec + nr) & 63], ent & ~msk);
          chk(rm_log[(b_rec + nr) & 63] == msk, {tag, " R4 record mask"},
              rm_log[(b_rec + nr) & 63], msk);
          chk(rp_log[(b_rec + nr) & 63] == ent[1:0], {tag, " R4 record perm"},
              64'(rp_log[(b_rec + nr) & 63]), 64'(ent[1:0]));
        end
        nr++;
      end
    end
    chk(n_rec - b_rec == nr, {tag, " R3 R8 record count"}, 64'(n_rec - b_rec), 64'(nr));
    chk(hold_err == b_hold, {tag, " R8 record held while stalled"}, 64'(hold_err - b_hold), 64'd0);
    chk(n_done - b_done == 1, {tag, " R9 R10 one done per walk"}, 64'(n_done - b_done), 64'd1);
  endtask

  initial begin
    tbl[0] = 64'h1234_5678_9ABC_DEF3;
    tbl[1] = 64'h0FED_CBA9_8765_4320;
    tbl[2] = 64'h0000_0040_0000_7FF1;
    tbl[3] = 64'hFFFF_FFFF_FFFF_F002;
    tbl[4] = 64'h5555_AAAA_5555_AAA4;
    tbl[5] = 64'h8000_0000_0001_2343;
    tbl[6] = 64'h0000_0000_0000_1001;
    tbl[7] = 64'h7777_0000_3333_0000;
    t_reset();
    t_quick(1'b1, 32'd6, "R7 skip");
    t_quick(1'b0, 32'd0, "R5 zero entries");
    run_walk(6'd12, 32'd6, 1'b0, 1'b0, "R2 R3 shift12");
    run_walk(6'd0, 32'd8, 1'b1, 1'b0, "R8 stalled shift0");
    run_walk(6'd63, 32'd3, 1'b0, 1'b0, "R6 wrap shift63");
    run_walk(6'd62, 32'd5, 1'b1, 1'b0, "R6 wrap shift62");
    run_walk(6'd4, 32'd5, 1'b0, 1'b1, "R10 busy start");
    t_quick(1'b1, 32'd3, "R7 skip after walks");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule